// File: doc/BRIEF.md
# Address-Translation Fence Sequencer

This block carries one supervisor translation-fence instruction from decode to completion. When a fence is accepted it captures the virtual-address and address-space operands together with the current privilege level and the virtual-memory trap status bit. In the following cycle it decides whether the instruction traps as illegal. If it does not trap, the block then makes the fence take effect in a fixed order:

1. Wait until the store buffer reports that all older stores have drained.
2. Hold off the page walker, and optionally kill it, until no walk is in flight.
3. Issue a filtered invalidate command to the translation cache.
4. Raise a pipeline flush so that younger instructions translate again.
5. Pulse done.

Each step waits on its own handshake. While the walker is held, walk results are refused at the install point. A walk that began before the fence therefore cannot fill an entry that the fence is about to remove. A register operand of x0 means "all" for either the address or the address space. A non-x0 address-space register that holds zero selects address space 0. In that case the invalidate is not marked as covering all address spaces, so the translation cache can keep its global entries. The address-space operand is read at its architectural maximum width, and only the implemented low bits are kept.

Top module: `tfence_seq`

## Requirements
- R1: A request is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the sequence ends, and a `req_valid` seen while `busy` is high starts no second sequence.
- R2: The cycle after acceptance, `trap_illegal` pulses for one cycle if the captured privilege is user (2'b00), or supervisor (2'b01) with `tvm_bit` set, or if `bare_only` is high. A trapped fence raises none of `walk_hold`, `inv_valid`, `flush_valid` or `done`. Machine privilege is 2'b11.
- R3: `walk_hold` and `inv_valid` stay low until `sb_empty` has been seen high after the trap check.
- R4: `walk_hold` is high from the end of store drain until the invalidate is accepted. With the default kill variant, `walk_kill` has the same timing. `walk_kill_asid_en` is high during this window exactly when the address-space operand was not x0, and `walk_kill_asid` then carries that address space.
- R5: `inv_valid` does not rise before `walk_idle` is high, and it is held until `inv_ready`. `inv_all_va` is set exactly when the address operand was x0, and `inv_va` is then zero. `inv_all_asid` is set exactly when the address-space operand was x0. `inv_asid` is the low ASID_W bits of `req_asid`, and the upper bits are ignored.
- R6: `flush_valid` rises after the invalidate is accepted and is held until `flush_ack`. `done` pulses for one cycle after the flush is acknowledged. At most one of `trap_illegal`, `inv_valid`, `flush_valid` and `done` is high in any cycle.
- R7: `fill_commit` follows `walk_fill` outside the hold window and is low during it, so walk results are dropped while the fence is in progress.
- R8: After reset, `busy`, `trap_illegal`, `walk_hold`, `walk_kill`, `inv_valid`, `flush_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Fence instruction presented by decode |
| req_va_is_x0 | input | 1 | Address operand register is x0 (all addresses) |
| req_va | input | VA_W | Virtual address operand |
| req_asid_is_x0 | input | 1 | Address-space operand register is x0 (all spaces) |
| req_asid | input | ASID_MAX_W | Address-space operand at architectural width |
| cur_priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| tvm_bit | input | 1 | Virtual-memory trap status bit |
| bare_only | input | 1 | Translation mode hardwired to bare |
| busy | output | 1 | Sequence in progress |
| trap_illegal | output | 1 | One-cycle illegal-instruction trap |
| sb_empty | input | 1 | Store buffer holds no older stores |
| walk_idle | input | 1 | No page walk in flight |
| walk_hold | output | 1 | Walker must not start or install walks |
| walk_kill | output | 1 | Abort in-flight walks (kill variant) |
| walk_kill_asid_en | output | 1 | Kill is restricted to one address space |
| walk_kill_asid | output | ASID_W | Address space for a restricted kill |
| walk_fill | input | 1 | Walker offers a result for installation |
| fill_commit | output | 1 | Walk result may be installed |
| inv_valid | output | 1 | Invalidate command to translation cache |
| inv_ready | input | 1 | Translation cache accepts the invalidate |
| inv_all_va | output | 1 | Invalidate all addresses |
| inv_va | output | VA_W | Address to invalidate |
| inv_all_asid | output | 1 | Invalidate all address spaces, globals included |
| inv_asid | output | ASID_W | Address space to invalidate |
| flush_valid | output | 1 | Pipeline flush request |
| flush_ack | input | 1 | Pipeline flush done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a walk result arriving while the fence holds the walker and the walker still reports a walk in flight. The stimulus must keep the store buffer non-empty for several cycles, release it, and then keep `walk_idle` low while offering `walk_fill`. Only in that window can a stale install or an early invalidate appear. The directed part of the bench builds this sequence step by step and then also stalls `inv_ready` and `flush_ack` to show that each strobe is held. A second request is also driven in the middle of a sequence to show that it is ignored.

// File: rtl/tfence_pkg.sv
package tfence_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_CHECK  = 3'd1,
      ST_DRAIN  = 3'd2,
      ST_KILL   = 3'd3,
      ST_INVAL  = 3'd4,
      ST_FLUSH  = 3'd5,
      ST_DONE   = 3'd6
   } fence_state_t;

   localparam logic [1:0] PRIV_USER  = 2'b00;
   localparam logic [1:0] PRIV_SUPER = 2'b01;
   localparam logic [1:0] PRIV_MACH  = 2'b11;
endpackage

// File: rtl/tfence_trap_check.sv
module tfence_trap_check
   import tfence_pkg::*;
(
   input  logic [1:0] priv,
   input  logic       tvm,
   input  logic       bare_only,
   output logic       illegal
);
   logic from_user;
   logic virt_trap;

   always_comb begin
      from_user = (priv == PRIV_USER);
      virt_trap = (priv == PRIV_SUPER) && tvm;
      illegal   = from_user || virt_trap || bare_only;
   end
endmodule

// File: rtl/tfence_walk_guard.sv
module tfence_walk_guard #(
   parameter int  ASID_W        = 9,
   parameter bit  KILL_INFLIGHT = 1'b1
) (
   input  logic              hold_win,
   input  logic              asid_all,
   input  logic [ASID_W-1:0] asid,
   input  logic              walk_fill,
   output logic              walk_hold,
   output logic              walk_kill,
   output logic              kill_asid_en,
   output logic [ASID_W-1:0] kill_asid,
   output logic              fill_commit
);
   assign walk_hold    = hold_win;
   assign kill_asid_en = hold_win && !asid_all;
   assign kill_asid    = hold_win ? asid : '0;
   assign fill_commit  = walk_fill && !hold_win;

   generate
      if (KILL_INFLIGHT) begin : g_kill
         assign walk_kill = hold_win;
      end else begin : g_drain
         assign walk_kill = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/tfence_fsm.sv
module tfence_fsm
   import tfence_pkg::*;
#(
   parameter int VA_W       = 39,
   parameter int ASID_W     = 9,
   parameter int ASID_MAX_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_va_is_x0,
   input  logic [VA_W-1:0]       req_va,
   input  logic                  req_asid_is_x0,
   input  logic [ASID_MAX_W-1:0] req_asid,
   input  logic [1:0]            cur_priv,
   input  logic                  tvm_bit,
   input  logic                  illegal,
   input  logic                  sb_empty,
   input  logic                  walk_idle,
   input  logic                  inv_ready,
   input  logic                  flush_ack,
   output logic [1:0]            cap_priv,
   output logic                  cap_tvm,
   output logic                  busy,
   output logic                  trap_illegal,
   output logic                  hold_win,
   output logic                  cap_asid_all,
   output logic [ASID_W-1:0]     cap_asid,
   output logic                  inv_valid,
   output logic                  inv_all_va,
   output logic [VA_W-1:0]       inv_va,
   output logic                  inv_all_asid,
   output logic [ASID_W-1:0]     inv_asid,
   output logic                  flush_valid,
   output logic                  done
);
   fence_state_t state_q, state_d;
   logic            va_all_q;
   logic [VA_W-1:0] va_q;
   logic            accept;

   assign accept = (state_q == ST_IDLE) && req_valid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req_valid) state_d = ST_CHECK;
         ST_CHECK: state_d = illegal ? ST_IDLE : ST_DRAIN;
         ST_DRAIN: if (sb_empty)  state_d = ST_KILL;
         ST_KILL:  if (walk_idle) state_d = ST_INVAL;
         ST_INVAL: if (inv_ready) state_d = ST_FLUSH;
         ST_FLUSH: if (flush_ack) state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         va_all_q     <= 1'b1;
         va_q         <= '0;
         cap_asid_all <= 1'b1;
         cap_asid     <= '0;
         cap_priv     <= PRIV_MACH;
         cap_tvm      <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            va_all_q     <= req_va_is_x0;
            va_q         <= req_va_is_x0 ? '0 : req_va;
            cap_asid_all <= req_asid_is_x0;
            cap_asid     <= req_asid_is_x0 ? '0 : req_asid[ASID_W-1:0];
            cap_priv     <= cur_priv;
            cap_tvm      <= tvm_bit;
         end
      end
   end

   assign busy         = (state_q != ST_IDLE);
   assign trap_illegal = (state_q == ST_CHECK) && illegal;
   assign hold_win     = (state_q == ST_KILL) || (state_q == ST_INVAL);
   assign inv_valid    = (state_q == ST_INVAL);
   assign inv_all_va   = va_all_q;
   assign inv_va       = va_q;
   assign inv_all_asid = cap_asid_all;
   assign inv_asid     = cap_asid;
   assign flush_valid  = (state_q == ST_FLUSH);
   assign done         = (state_q == ST_DONE);

   // R2: a trapped fence leaves without touching walker, cache or pipeline
   p_trap_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trap_illegal |=> (state_q == ST_IDLE));

   // R3: walker hold only begins once stores have drained
   p_hold_after_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_win) |-> $past(sb_empty));

   // R5: invalidate never precedes walker idle
   p_inv_after_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inv_valid) |-> $past(walk_idle));

   // R6: done follows an acknowledged flush
   p_done_after_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(flush_valid && flush_ack));
endmodule

// File: rtl/tfence_seq.sv
module tfence_seq
   import tfence_pkg::*;
#(
   parameter int VA_W          = 39,
   parameter int ASID_W        = 9,
   parameter int ASID_MAX_W    = 16,
   parameter bit KILL_INFLIGHT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_va_is_x0,
   input  logic [VA_W-1:0]       req_va,
   input  logic                  req_asid_is_x0,
   input  logic [ASID_MAX_W-1:0] req_asid,
   input  logic [1:0]            cur_priv,
   input  logic                  tvm_bit,
   input  logic                  bare_only,
   output logic                  busy,
   output logic                  trap_illegal,
   input  logic                  sb_empty,
   input  logic                  walk_idle,
   output logic                  walk_hold,
   output logic                  walk_kill,
   output logic                  walk_kill_asid_en,
   output logic [ASID_W-1:0]     walk_kill_asid,
   input  logic                  walk_fill,
   output logic                  fill_commit,
   output logic                  inv_valid,
   input  logic                  inv_ready,
   output logic                  inv_all_va,
   output logic [VA_W-1:0]       inv_va,
   output logic                  inv_all_asid,
   output logic [ASID_W-1:0]     inv_asid,
   output logic                  flush_valid,
   input  logic                  flush_ack,
   output logic                  done
);
   generate
      if (ASID_W < 1 || ASID_W > ASID_MAX_W) begin : g_bad_asid
         $error("tfence_seq: ASID_W must be in 1..ASID_MAX_W");
      end
      if (VA_W < 1) begin : g_bad_va
         $error("tfence_seq: VA_W must be positive");
      end
   endgenerate

   logic [1:0]        cap_priv;
   logic              cap_tvm;
   logic              illegal;
   logic              hold_win;
   logic              cap_asid_all;
   logic [ASID_W-1:0] cap_asid;

   tfence_trap_check u_trap (
      .priv      (cap_priv),
      .tvm       (cap_tvm),
      .bare_only (bare_only),
      .illegal   (illegal)
   );

   tfence_fsm #(
      .VA_W       (VA_W),
      .ASID_W     (ASID_W),
      .ASID_MAX_W (ASID_MAX_W)
   ) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_va_is_x0   (req_va_is_x0),
      .req_va         (req_va),
      .req_asid_is_x0 (req_asid_is_x0),
      .req_asid       (req_asid),
      .cur_priv       (cur_priv),
      .tvm_bit        (tvm_bit),
      .illegal        (illegal),
      .sb_empty       (sb_empty),
      .walk_idle      (walk_idle),
      .inv_ready      (inv_ready),
      .flush_ack      (flush_ack),
      .cap_priv       (cap_priv),
      .cap_tvm        (cap_tvm),
      .busy           (busy),
      .trap_illegal   (trap_illegal),
      .hold_win       (hold_win),
      .cap_asid_all   (cap_asid_all),
      .cap_asid       (cap_asid),
      .inv_valid      (inv_valid),
      .inv_all_va     (inv_all_va),
      .inv_va         (inv_va),
      .inv_all_asid   (inv_all_asid),
      .inv_asid       (inv_asid),
      .flush_valid    (flush_valid),
      .done           (done)
   );

   tfence_walk_guard #(
      .ASID_W        (ASID_W),
      .KILL_INFLIGHT (KILL_INFLIGHT)
   ) u_guard (
      .hold_win     (hold_win),
      .asid_all     (cap_asid_all),
      .asid         (cap_asid),
      .walk_fill    (walk_fill),
      .walk_hold    (walk_hold),
      .walk_kill    (walk_kill),
      .kill_asid_en (walk_kill_asid_en),
      .kill_asid    (walk_kill_asid),
      .fill_commit  (fill_commit)
   );

   // R6: strobes toward trap, cache, pipeline and retire never overlap
   p_strobes_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({trap_illegal, inv_valid, flush_valid, done}));

   // R7: no walk result is installed while the invalidate is outstanding
   p_no_fill_at_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> !fill_commit);

   // R2: a trapping fence never raises a side effect in the same cycle
   p_trap_no_effect_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trap_illegal |-> !(walk_hold || inv_valid || flush_valid || done));
endmodule

// File: tb/tfence_seq_bench.sv
module tfence_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int VA_W = 39;
   localparam int ASID_W = 9;
   localparam int ASID_MAX_W = 16;
   // fields: [6:5] priv, [4] tvm, [3] bare_only, [2] va_x0, [1] asid_x0, [0] expect trap
   localparam logic [6:0] VEC [8] = '{
      7'b01_0_0_0_0_0,
      7'b01_0_0_1_1_0,
      7'b11_1_0_0_0_0,
      7'b01_1_0_0_0_1,
      7'b00_0_0_1_1_1,
      7'b11_0_1_0_0_1,
      7'b01_0_0_1_0_0,
      7'b01_0_0_0_1_0
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, req_va_is_x0 = 0, req_asid_is_x0 = 0;
   logic [VA_W-1:0] req_va = '0;
   logic [ASID_MAX_W-1:0] req_asid = '0;
   logic [1:0] cur_priv = 2'b11;
   logic tvm_bit = 0, bare_only = 0;
   logic sb_empty = 1, walk_idle = 1, walk_fill = 0, inv_ready = 1, flush_ack = 1;
   logic busy, trap_illegal, walk_hold, walk_kill, walk_kill_asid_en, fill_commit;
   logic inv_valid, inv_all_va, inv_all_asid, flush_valid, done;
   logic [ASID_W-1:0] walk_kill_asid, inv_asid;
   logic [VA_W-1:0] inv_va;
   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tfence_seq #(.VA_W(VA_W), .ASID_W(ASID_W), .ASID_MAX_W(ASID_MAX_W)) u_tfence_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va_is_x0(req_va_is_x0),
      .req_va(req_va), .req_asid_is_x0(req_asid_is_x0), .req_asid(req_asid),
      .cur_priv(cur_priv), .tvm_bit(tvm_bit), .bare_only(bare_only), .busy(busy),
      .trap_illegal(trap_illegal), .sb_empty(sb_empty), .walk_idle(walk_idle),
      .walk_hold(walk_hold), .walk_kill(walk_kill), .walk_kill_asid_en(walk_kill_asid_en),
      .walk_kill_asid(walk_kill_asid), .walk_fill(walk_fill), .fill_commit(fill_commit),
      .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_all_va(inv_all_va), .inv_va(inv_va),
      .inv_all_asid(inv_all_asid), .inv_asid(inv_asid), .flush_valid(flush_valid),
      .flush_ack(flush_ack), .done(done)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] pv, input logic tv, input logic bo,
                        input logic vx0, input logic ax0,
                        input logic [VA_W-1:0] va, input logic [ASID_MAX_W-1:0] asid);
      cur_priv = pv; tvm_bit = tv; bare_only = bo;
      req_va_is_x0 = vx0; req_asid_is_x0 = ax0; req_va = va; req_asid = asid;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      // R8: outputs quiet in reset
      check({busy, trap_illegal, walk_hold, walk_kill, inv_valid, flush_valid, done} == 7'b0,
            "R8 reset", {busy, trap_illegal, walk_hold, walk_kill, inv_valid, flush_valid, done}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy, "R8 idle after reset", busy, 0);

      // table walk: all handshakes ready
      for (int i = 0; i < 8; i++) begin
         logic [6:0] v;
         logic [VA_W-1:0] va;
         logic [ASID_MAX_W-1:0] asid;
         bit trap_s, inv_s, flush_s, done_s, inv_avx, inv_aax, ken;
         logic [VA_W-1:0] iva;
         logic [ASID_W-1:0] ias;
         v = VEC[i];
         va = VA_W'(64'h12_3456_7000 + i * 4096);
         asid = 16'hFE00 | 16'(i * 37);
         trap_s = 0; inv_s = 0; flush_s = 0; done_s = 0;
         inv_avx = 0; inv_aax = 0; ken = 0; iva = '0; ias = '0;
         issue(v[6:5], v[4], v[3], v[2], v[1], va, asid);
         for (int c = 0; c < 12; c++) begin
            if (trap_illegal) trap_s = 1;
            if (walk_kill_asid_en) ken = 1;
            if (inv_valid) begin
               inv_s = 1; inv_avx = inv_all_va; inv_aax = inv_all_asid;
               iva = inv_va; ias = inv_asid;
            end
            if (flush_valid) flush_s = 1;
            if (done) done_s = 1;
            @(negedge clk);
         end
         check(trap_s == v[0], "R2 trap decision", trap_s, v[0]);
         if (v[0]) begin
            check(!inv_s && !flush_s && !done_s, "R2 trapped has no effect",
                  {inv_s, flush_s, done_s}, 0);
         end else begin
            check(inv_s && flush_s && done_s, "R6 full sequence", {inv_s, flush_s, done_s}, 3'b111);
            check(inv_avx == v[2], "R5 all-va flag", inv_avx, v[2]);
            check(inv_aax == v[1], "R5 all-asid flag", inv_aax, v[1]);
            check(iva == (v[2] ? '0 : va), "R5 inv va", iva, v[2] ? 0 : va);
            check(ias == (v[1] ? '0 : asid[ASID_W-1:0]), "R5 asid low bits",
                  ias, v[1] ? 0 : asid[ASID_W-1:0]);
            check(ken == !v[1], "R4 kill asid filter", ken, !v[1]);
         end
         check(!busy, "R1 idle at end", busy, 0);
      end

      // R5: non-x0 ASID register holding zero spares globals
      begin
         bit aax;
         logic [ASID_W-1:0] ias;
         aax = 1; ias = '1;
         issue(2'b01, 0, 0, 1, 0, '0, 16'h0000);
         for (int c = 0; c < 10; c++) begin
            if (inv_valid) begin aax = inv_all_asid; ias = inv_asid; end
            @(negedge clk);
         end
         check(!aax && ias == 0, "R5 zero asid not all", {aax, ias}, 0);
      end

      // directed stall sequence
      sb_empty = 0; walk_idle = 0; inv_ready = 0; flush_ack = 0;
      issue(2'b01, 0, 0, 0, 1, VA_W'(64'h4000), '0);
      for (int c = 0; c < 6; c++) @(negedge clk);
      check(busy, "R1 busy while draining", busy, 1);
      check(!walk_hold && !inv_valid, "R3 stalled on stores", {walk_hold, inv_valid}, 0);
      // second request while busy
      issue(2'b01, 0, 0, 1, 1, '0, '0);
      sb_empty = 1;
      @(negedge clk);
      check(walk_hold && walk_kill, "R4 hold and kill after drain", {walk_hold, walk_kill}, 2'b11);
      walk_fill = 1;
      @(negedge clk);
      check(!fill_commit, "R7 fill dropped while held", fill_commit, 0);
      for (int c = 0; c < 3; c++) @(negedge clk);
      check(!inv_valid, "R5 waits for walker idle", inv_valid, 0);
      walk_idle = 1;
      @(negedge clk);
      check(inv_valid, "R5 invalidate after idle", inv_valid, 1);
      @(negedge clk);
      @(negedge clk);
      check(inv_valid && walk_hold, "R4 inv held until ready", {inv_valid, walk_hold}, 2'b11);
      inv_ready = 1;
      @(negedge clk);
      check(flush_valid && !walk_hold, "R6 flush after inv", {flush_valid, walk_hold}, 2'b10);
      check(fill_commit, "R7 fill passes outside window", fill_commit, 1);
      walk_fill = 0;
      @(negedge clk);
      check(flush_valid && !done, "R6 flush held", {flush_valid, done}, 2'b10);
      flush_ack = 1;
      @(negedge clk);
      check(done, "R6 done pulse", done, 1);
      @(negedge clk);
      check(!done && !busy, "R6 done one cycle", {done, busy}, 0);
      begin
         int extra;
         extra = 0;
         for (int c = 0; c < 10; c++) begin
            if (busy) extra++;
            @(negedge clk);
         end
         check(extra == 0, "R1 busy request ignored", extra, 0);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule